// File: doc/BRIEF.md
# Ready-Stretched Bus Master Sequencer

This block is the host side of a simple parallel memory bus. It takes one request at a time from a front end. A request carries an address, write data and a direction. The block runs that request as a single read or write on a bus made of address, data, direction and a ready input. When the access ends, it returns the read data together with a one-cycle done pulse.

Every access lasts at least two bus cycles:

- **First cycle:** the address, the direction and a bus-valid strobe are driven. Downstream logic can decode chip selects from the strobe.
- **Second cycle:** for a write, the data bus is driven as well, so the address has had a cycle to settle first.
- **Ready sampling:** ready is sampled from the second cycle on. A device may pull ready low as early as the first cycle without any effect. From the second cycle on, each low sample adds one wait cycle, and all bus outputs hold their values through it.
- **Completion:** on the first high sample, a read captures the data bus. The next cycle is the done cycle, in which all bus drives are released.

A wait-count limit raises an error flag when a device keeps the bus waiting too long.

Top module: `rdy_bus_master`

## Requirements
- R1: After reset, bus_valid, bus_addr_oe, bus_data_oe, rsp_done and wait_err are all 0, and req_ready is 1.
- R2: A request is taken on a rising edge where req_valid and req_ready are both 1. In the following cycle, bus_valid and bus_addr_oe are 1, bus_addr equals the request address, and bus_write equals the request direction (1 = write).
- R3: In the first access cycle bus_data_oe is 0. From the second cycle until completion, bus_data_oe is 1 for a write (with bus_wdata equal to the request data) and 0 for a read.
- R4: bus_ready is ignored in the first access cycle: a low level there adds no wait cycle. rsp_done is never 1 in the first or second access cycle.
- R5: While bus_ready is sampled low from the second cycle on, the access continues another cycle and bus_addr, bus_write, bus_valid, bus_data_oe and bus_wdata hold their values. Changes on the request inputs during this time have no effect.
- R6: A read returns on rsp_rdata, during the done cycle, the value bus_rdata had at the edge where bus_ready was first sampled high.
- R7: The done cycle follows the edge that samples bus_ready high. In it, rsp_done is 1 for exactly one cycle and bus_valid, bus_addr_oe and bus_data_oe are all 0.
- R8: req_ready is 0 from acceptance through the done cycle and is 1 again in the cycle after done.
- R9: With MAX_WAIT nonzero, wait_err becomes 1 once bus_ready has been sampled low more than MAX_WAIT times in one access. It stays 1 until the next request is accepted, and it is 0 in that request's first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Front end presents a request |
| req_write | input | 1 | Request direction, 1 = write |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ready | output | 1 | Block is idle and will take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data, valid with rsp_done |
| wait_err | output | 1 | Wait-count limit exceeded |
| bus_valid | output | 1 | Access in progress, for chip-select decode |
| bus_write | output | 1 | Bus direction, 1 = write |
| bus_addr | output | AW | Address bus value |
| bus_addr_oe | output | 1 | Address bus drive enable |
| bus_wdata | output | DW | Data bus value for writes |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_rdata | input | DW | Data bus value seen on reads |
| bus_ready | input | 1 | Device ready |

## Verification
Completion and the wait-limit crossing can fall on the same access boundary. A ready that returns high on the sample right after exactly MAX_WAIT low samples must finish cleanly. One more low sample must raise wait_err, and the flag must still be up when done arrives. Directed accesses with MAX_WAIT and MAX_WAIT+1 wait cycles provoke both sides of that boundary. The bench judges done timing and the flag against a bench function of the wait count. A second overlap, a low ready in the first cycle of an access, is mixed into the random accesses and must not move the done cycle.

// File: rtl/rdy_bus_master.sv
module rdy_bus_master #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int MAX_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          wait_err,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_addr_oe,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_data_oe,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);
  localparam int CW = $clog2(MAX_WAIT + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_XFER, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, err_q;
  logic [CW-1:0] wcnt;

  wire take   = (st == S_IDLE) && req_valid;
  wire stall  = (st == S_XFER) && !bus_ready;
  wire finish = (st == S_XFER) && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      wcnt    <= '0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st      <= S_ADDR;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          wcnt    <= '0;
          err_q   <= 1'b0;
        end
        S_ADDR: st <= S_XFER;
        S_XFER: begin
          if (finish) begin
            st <= S_DONE;
            if (!wr_q) rdata_q <= bus_rdata;
          end
          if (stall) begin
            if (wcnt != LIMIT) wcnt <= wcnt + 1'b1;
            else if (MAX_WAIT != 0) err_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == S_IDLE);
  assign rsp_done    = (st == S_DONE);
  assign rsp_rdata   = rdata_q;
  assign wait_err    = err_q;
  assign bus_valid   = (st == S_ADDR) || (st == S_XFER);
  assign bus_addr_oe = bus_valid;
  assign bus_write   = wr_q;
  assign bus_addr    = addr_q;
  assign bus_wdata   = wdata_q;
  assign bus_data_oe = (st == S_XFER) && wr_q;
endmodule

module rdy_bus_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic          wait_err,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic          bus_addr_oe,
  input logic          bus_data_oe,
  input logic [AW-1:0] bus_addr
);
  a_r3_no_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_addr_oe) |-> !bus_data_oe);
  a_r4_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |=> !rsp_done);
  a_r5_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !bus_valid && !bus_addr_oe && !bus_data_oe);
  a_r8_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wait_err && !(req_valid && req_ready) |=> wait_err);
endmodule

bind rdy_bus_master rdy_bus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .wait_err(wait_err), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_addr_oe(bus_addr_oe), .bus_data_oe(bus_data_oe),
  .bus_addr(bus_addr)
);

// File: tb/rdy_bus_master_bench.sv
module rdy_bus_master_bench;
  localparam int AW = 16, DW = 16, MAXW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_rdata = '0;
  logic bus_ready = 1'b1;
  logic req_ready, rsp_done, wait_err, bus_valid, bus_write, bus_addr_oe, bus_data_oe;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rdy_bus_master #(.AW(AW), .DW(DW), .MAX_WAIT(MAXW)) u_rdy_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .wait_err(wait_err),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  function automatic bit exp_err(input int nw);
    return (MAXW != 0) && (nw > MAXW);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit c1low, input int nw);
    logic [DW-1:0] rd;
    rd = DW'($urandom);
    chk("R8 idle before request", {31'd0, req_ready}, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0; req_write = ~wr;
    req_addr = AW'($urandom); req_wdata = DW'($urandom);
    chk("R2 first cycle valid/addr/dir", {bus_valid, bus_addr_oe, bus_write, bus_addr},
        {1'b1, 1'b1, wr, a});
    chk("R3 no data drive in first cycle", {31'd0, bus_data_oe}, 0);
    chk("R9 flag cleared on accept", {31'd0, wait_err}, 0);
    bus_ready = !c1low;
    step();
    for (int i = 0; i <= nw; i++) begin
      chk("R5 held through wait", {bus_valid, bus_write, bus_data_oe, bus_addr},
          {1'b1, wr, wr, a});
      if (wr) chk("R3 write data driven", {16'd0, bus_wdata}, {16'd0, d});
      chk("R4 no done before ready sample", {31'd0, rsp_done}, 0);
      bus_ready = (i == nw);
      bus_rdata = (i == nw) ? rd : DW'($urandom);
      step();
    end
    chk("R7 done with buses released",
        {rsp_done, bus_valid, bus_addr_oe, bus_data_oe}, {1'b1, 3'b000});
    chk("R8 busy in done cycle", {31'd0, req_ready}, 0);
    chk("R9 wait limit flag", {31'd0, wait_err}, {31'd0, exp_err(nw)});
    if (!wr) chk("R6 read data", {16'd0, rsp_rdata}, {16'd0, rd});
    bus_ready = 1'($urandom);
    bus_rdata = DW'($urandom);
    step();
    chk("R7 done is one cycle", {31'd0, rsp_done}, 0);
    chk("R8 idle after done", {31'd0, req_ready}, 1);
    chk("R9 flag held until next accept", {31'd0, wait_err}, {31'd0, exp_err(nw)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state",
        {bus_valid, bus_addr_oe, bus_data_oe, rsp_done, wait_err, req_ready}, 6'b000001);
    run(1'b0, 16'h1234, 16'h0000, 1'b0, 0);
    run(1'b1, 16'hABCD, 16'h5A5A, 1'b1, 0);   // R4 low ready in first cycle only
    run(1'b0, 16'h0F0F, 16'h0000, 1'b1, 2);
    run(1'b1, 16'hFFFF, 16'hC3C3, 1'b0, MAXW);      // R9 at limit, no flag
    run(1'b0, 16'h8000, 16'h0000, 1'b0, MAXW + 1);  // R9 one past limit
    run(1'b1, 16'h0001, 16'h7E7E, 1'b1, MAXW + 3);
    run(1'b0, 16'h2222, 16'h0000, 1'b0, 1);         // R9 flag clears on this accept
    for (int k = 0; k < 60; k++)
      run(1'($urandom), AW'($urandom), DW'($urandom), 1'($urandom), int'($urandom % 8));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule